// File: doc/BRIEF.md
# Display link sideband request framer

This block turns one sideband request (a 20-bit target address, a 4-bit command, a payload length of up to sixteen bytes and the write data) into the byte stream that a sideband transport sends. The stream opens with a four-byte header and, for writes, continues with the payload. The stream leaves through a valid/ready byte port that marks the final byte. Bad requests are refused at once, before anything is sent.

Once the stream has gone out, the block waits for the transport's one-byte completion status and the number of bytes the sink returned. It then emits a single-cycle result: a status class, the sink's reply code and a transfer count. The layer that drives the physical line and the retry policy sit outside this block.

Top module: `auxreq_packer`

## Requirements
- R1: A request whose length exceeds MAX_PAY (16) completes with status code 3 (too big) one cycle after acceptance. No byte is sent, and the reply and count read 0.
- R2: The command is masked with 4'hB, which clears bit 2, the continuation bit. If the masked value is not 0 (bridged write), 1 (bridged read), 8 (native write) or 9 (native read), the request completes with status code 4 (invalid) and no byte is sent. A command is a read when bit 0 is set.
- R3: Byte 0 sent is address[7:0]. Byte 1 is address[15:8]. Byte 2 carries the command in bits 7:4 and address[19:16] in bits 3:0.
- R4: Bits 3:0 of byte 3 hold length minus one, or 0 when the length is zero.
- R5: A write sends 4 + length bytes, with the payload in order after the header, payload byte i taken from req_data[8i+7:8i]. Bits 7:4 of byte 3 hold (4 + length) mod 16, or 3 when the length is zero.
- R6: A read sends only the four header bytes. Bits 7:4 of byte 3 hold 4, or 3 when the length is zero.
- R7: A completion status byte of 1 gives status code 1 (timeout). A status byte of 2 or 3 gives status code 2 (I/O error). In both cases the reply and count read 0.
- R8: Any other status byte gives status code 0 (success), and the reply equals bits 7:4 of that byte.
- R9: On success, a write reports its own length as the count. A read reports the smaller of the received length and the requested length.
- R10: While tx_valid is high and tx_ready is low, tx_data and tx_last hold steady. tx_last is high on the final byte only, and tx_valid drops after that byte is taken.
- R11: req_ready is high only when the block is idle. done pulses for exactly one cycle per request. rsp_valid has no effect unless the block is waiting for a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_addr | input | ADDR_W | Target address |
| req_cmd | input | 4 | Request command |
| req_len | input | LEN_W | Payload length in bytes |
| req_data | input | MAX_PAY*8 | Write payload, byte 0 in the low bits |
| tx_valid | output | 1 | Stream byte available |
| tx_ready | input | 1 | Transport takes the byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the request |
| rsp_valid | input | 1 | Completion available |
| rsp_status | input | 8 | Completion status byte |
| rsp_len | input | LEN_W | Bytes returned by the sink |
| done | output | 1 | Result valid pulse |
| res_status | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 too big, 4 invalid |
| res_reply | output | 4 | Sink reply code |
| res_count | output | LEN_W | Transfer count |

## Verification
The bench builds the block with its default parameters: a 20-bit address and MAX_PAY of 16, which makes LEN_W six bits. The wide length field lets the bench offer a 17-byte request and so reach the too-big path. Sixteen payload bytes bring within reach the lengths from 12 upward, where the size nibble of byte 3 wraps modulo 16. The 20-bit address fills the low nibble of byte 2.

// File: rtl/auxreq_pkg.sv
`timescale 1ns/1ps
package auxreq_pkg;

   localparam int CMD_W = 4;
   localparam int HDR_BYTES = 4;

   // continuation bit is masked before the command is classified
   localparam logic [CMD_W-1:0] CMD_CLASS_MASK = 4'hB;
   localparam logic [CMD_W-1:0] CMD_BR_WR  = 4'h0;
   localparam logic [CMD_W-1:0] CMD_BR_RD  = 4'h1;
   localparam logic [CMD_W-1:0] CMD_NAT_WR = 4'h8;
   localparam logic [CMD_W-1:0] CMD_NAT_RD = 4'h9;

   typedef enum logic [2:0] {
      RES_OK      = 3'd0,
      RES_TIMEOUT = 3'd1,
      RES_IOERR   = 3'd2,
      RES_TOOBIG  = 3'd3,
      RES_INVAL   = 3'd4
   } res_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEND = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;

endpackage

// File: rtl/auxreq_hdr.sv
`timescale 1ns/1ps
module auxreq_hdr
   import auxreq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int MAX_PAY = 16,
   parameter int LEN_W   = 6,
   parameter int CNT_W   = 5
) (
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [CMD_W-1:0]            cmd_i,
   input  logic [LEN_W-1:0]            len_i,
   output logic [HDR_BYTES-1:0][7:0]   hdr_o,
   output logic [CNT_W-1:0]            total_o,
   output logic                        too_big_o,
   output logic                        bad_cmd_o,
   output logic                        is_read_o
);

   logic [CMD_W-1:0] cmd_class;
   logic [3:0]       addr_top;
   logic [3:0]       size_lo;
   logic [3:0]       size_hi;
   logic             len_zero;

   generate
      if (ADDR_W > 16) begin : g_wide_addr
         assign addr_top = 4'(addr_i[ADDR_W-1:16]);
      end else begin : g_narrow_addr
         assign addr_top = 4'h0;
      end
   endgenerate

   assign cmd_class = cmd_i & CMD_CLASS_MASK;
   assign is_read_o = cmd_i[0];
   assign bad_cmd_o = !(cmd_class == CMD_BR_WR || cmd_class == CMD_BR_RD ||
                        cmd_class == CMD_NAT_WR || cmd_class == CMD_NAT_RD);
   assign too_big_o = (len_i > LEN_W'(MAX_PAY));
   assign len_zero  = (len_i == '0);

   always_comb begin
      size_lo = len_zero ? 4'h0 : 4'(len_i - 1'b1);
      if (len_zero)       size_hi = 4'd3;
      else if (is_read_o) size_hi = 4'd4;
      else                size_hi = 4'(len_i + LEN_W'(HDR_BYTES));
   end

   assign hdr_o[0] = addr_i[7:0];
   assign hdr_o[1] = addr_i[15:8];
   assign hdr_o[2] = {cmd_i, addr_top};
   assign hdr_o[3] = {size_hi, size_lo};

   assign total_o = is_read_o ? CNT_W'(HDR_BYTES)
                              : CNT_W'(len_i) + CNT_W'(HDR_BYTES);

endmodule

// File: rtl/auxreq_tx.sv
`timescale 1ns/1ps
module auxreq_tx
   import auxreq_pkg::*;
#(
   parameter int MAX_PAY = 16,
   parameter int CNT_W   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [HDR_BYTES-1:0][7:0]  hdr_i,
   input  logic [MAX_PAY*8-1:0]       pay_i,
   input  logic [CNT_W-1:0]           total_i,
   output logic                       valid_o,
   input  logic                       ready_i,
   output logic [7:0]                 data_o,
   output logic                       last_o,
   output logic                       sent_o
);

   localparam int SLOTS = 2**CNT_W;

   logic [SLOTS*8-1:0] flat;
   logic [CNT_W-1:0]   idx_q;
   logic [CNT_W-1:0]   total_q;
   logic               active_q;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [7:0] nxt;
      logic [7:0] slot_q;
      if (g < HDR_BYTES) begin : g_hdr
         assign nxt = hdr_i[g];
      end else if (g < HDR_BYTES + MAX_PAY) begin : g_pay
         assign nxt = pay_i[(g-HDR_BYTES)*8 +: 8];
      end else begin : g_pad
         assign nxt = 8'h00;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      slot_q <= 8'h00;
         else if (load_i) slot_q <= nxt;
      end
      assign flat[g*8 +: 8] = slot_q;
   end

   assign valid_o = active_q;
   assign data_o  = flat[idx_q*8 +: 8];
   assign last_o  = active_q && (idx_q == total_q - 1'b1);
   assign sent_o  = active_q && ready_i && last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         total_q  <= '0;
         active_q <= 1'b0;
      end else if (load_i) begin
         idx_q    <= '0;
         total_q  <= total_i;
         active_q <= 1'b1;
      end else if (active_q && ready_i) begin
         if (last_o) active_q <= 1'b0;
         else        idx_q    <= idx_q + 1'b1;
      end
   end

   // R10: a stalled byte must not move
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o));

   // R10: the stream ends after its final byte is taken
   assert_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && ready_i && last_o && !load_i |=> !valid_o);

endmodule

// File: rtl/auxreq_rsp.sv
`timescale 1ns/1ps
module auxreq_rsp
   import auxreq_pkg::*;
#(
   parameter int LEN_W = 6
) (
   input  logic [7:0]       status_i,
   input  logic [LEN_W-1:0] rx_len_i,
   input  logic [LEN_W-1:0] req_len_i,
   input  logic             is_read_i,
   output res_e             res_o,
   output logic [3:0]       reply_o,
   output logic [LEN_W-1:0] count_o
);

   always_comb begin
      res_o   = RES_OK;
      reply_o = 4'h0;
      count_o = '0;
      case (status_i)
         8'd1:       res_o = RES_TIMEOUT;
         8'd2, 8'd3: res_o = RES_IOERR;
         default: begin
            reply_o = status_i[7:4];
            if (!is_read_i)               count_o = req_len_i;
            else if (rx_len_i > req_len_i) count_o = req_len_i;
            else                          count_o = rx_len_i;
         end
      endcase
   end

endmodule

// File: rtl/auxreq_packer.sv
`timescale 1ns/1ps
module auxreq_packer
   import auxreq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int MAX_PAY = 16,
   localparam int LEN_W  = $clog2(MAX_PAY + 1) + 1,
   localparam int CNT_W  = $clog2(MAX_PAY + HDR_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [3:0]           req_cmd,
   input  logic [LEN_W-1:0]     req_len,
   input  logic [MAX_PAY*8-1:0] req_data,
   output logic                 tx_valid,
   input  logic                 tx_ready,
   output logic [7:0]           tx_data,
   output logic                 tx_last,
   input  logic                 rsp_valid,
   input  logic [7:0]           rsp_status,
   input  logic [LEN_W-1:0]     rsp_len,
   output logic                 done,
   output logic [2:0]           res_status,
   output logic [3:0]           res_reply,
   output logic [LEN_W-1:0]     res_count
);

   generate
      if (MAX_PAY < 1 || MAX_PAY > 16) begin : g_bad_pay
         $error("MAX_PAY must lie in 1..16 so lengths fit a nibble");
      end
      if (ADDR_W < 16 || ADDR_W > 20) begin : g_bad_addr
         $error("ADDR_W must lie in 16..20");
      end
   endgenerate

   phase_e                     phase_q;
   logic [HDR_BYTES-1:0][7:0]  hdr;
   logic [CNT_W-1:0]           total;
   logic                       too_big, bad_cmd, is_read;
   logic                       accept, reject, load, sent;
   logic                       rd_q;
   logic [LEN_W-1:0]           len_q;
   res_e                       dec_res;
   logic [3:0]                 dec_reply;
   logic [LEN_W-1:0]           dec_count;
   res_e                       res_q;
   logic [3:0]                 reply_q;
   logic [LEN_W-1:0]           count_q;
   logic                       done_q;

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign reject    = too_big || bad_cmd;
   assign load      = accept && !reject;

   auxreq_hdr #(
      .ADDR_W (ADDR_W), .MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .CNT_W(CNT_W)
   ) u_hdr (
      .addr_i    (req_addr),
      .cmd_i     (req_cmd),
      .len_i     (req_len),
      .hdr_o     (hdr),
      .total_o   (total),
      .too_big_o (too_big),
      .bad_cmd_o (bad_cmd),
      .is_read_o (is_read)
   );

   auxreq_tx #(.MAX_PAY(MAX_PAY), .CNT_W(CNT_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .hdr_i   (hdr),
      .pay_i   (req_data),
      .total_i (total),
      .valid_o (tx_valid),
      .ready_i (tx_ready),
      .data_o  (tx_data),
      .last_o  (tx_last),
      .sent_o  (sent)
   );

   auxreq_rsp #(.LEN_W(LEN_W)) u_rsp (
      .status_i  (rsp_status),
      .rx_len_i  (rsp_len),
      .req_len_i (len_q),
      .is_read_i (rd_q),
      .res_o     (dec_res),
      .reply_o   (dec_reply),
      .count_o   (dec_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         rd_q    <= 1'b0;
         len_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (load) begin
               phase_q <= PH_SEND;
               rd_q    <= is_read;
               len_q   <= req_len;
            end
            PH_SEND: if (sent)      phase_q <= PH_WAIT;
            PH_WAIT: if (rsp_valid) phase_q <= PH_IDLE;
            default:                phase_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         res_q   <= RES_OK;
         reply_q <= 4'h0;
         count_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept && reject) begin
            done_q  <= 1'b1;
            res_q   <= too_big ? RES_TOOBIG : RES_INVAL;
            reply_q <= 4'h0;
            count_q <= '0;
         end else if (phase_q == PH_WAIT && rsp_valid) begin
            done_q  <= 1'b1;
            res_q   <= dec_res;
            reply_q <= dec_reply;
            count_q <= dec_count;
         end
      end
   end

   assign done       = done_q;
   assign res_status = res_q;
   assign res_reply  = reply_q;
   assign res_count  = count_q;

   // R1: an oversize request finishes straight from idle with nothing sent
   assert_oversize_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done && res_status == RES_TOOBIG |-> !tx_valid && $past(phase_q == PH_IDLE));

   // R2: a bad command finishes straight from idle with nothing sent
   assert_badcmd_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done && res_status == RES_INVAL |-> !tx_valid && $past(phase_q == PH_IDLE));

   // R7: transport errors carry no reply and no count
   assert_err_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done && (res_status == RES_TIMEOUT || res_status == RES_IOERR)
      |-> res_reply == 4'h0 && res_count == '0);

   // R9: a reported count never exceeds the requested length
   assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done && res_status == RES_OK |-> res_count <= len_q);

   // R11: no new request is taken while a stream is in flight
   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !req_ready);

   // R11: the result pulse lasts a single cycle
   assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done && !$past(accept) |=> !done);

endmodule

// File: tb/auxreq_packer_tb.sv
`timescale 1ns/1ps
module auxreq_packer_tb;

   localparam int ADDR_W  = 20;
   localparam int MAX_PAY = 16;
   localparam int LEN_W   = $clog2(MAX_PAY + 1) + 1;

   logic                 clk = 1'b0;
   logic                 rst_n;
   logic                 req_valid;
   logic                 req_ready;
   logic [ADDR_W-1:0]    req_addr;
   logic [3:0]           req_cmd;
   logic [LEN_W-1:0]     req_len;
   logic [MAX_PAY*8-1:0] req_data;
   logic                 tx_valid;
   logic                 tx_ready;
   logic [7:0]           tx_data;
   logic                 tx_last;
   logic                 rsp_valid;
   logic [7:0]           rsp_status;
   logic [LEN_W-1:0]     rsp_len;
   logic                 done;
   logic [2:0]           res_status;
   logic [3:0]           res_reply;
   logic [LEN_W-1:0]     res_count;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  ended  = 1'b0;

   always #2.5 clk = ~clk;

   auxreq_packer #(.ADDR_W(ADDR_W), .MAX_PAY(MAX_PAY)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_cmd(req_cmd), .req_len(req_len), .req_data(req_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_len(rsp_len),
      .done(done), .res_status(res_status), .res_reply(res_reply), .res_count(res_count)
   );

   task automatic check_eq(input string rq, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   // full request: drives, collects the stream, completes, checks the result
   task automatic do_xfer(input logic [19:0] a, input logic [3:0] c, input int n,
                          input bit stall, input logic [7:0] st, input int rl,
                          input string rq);
      logic [7:0] expb [20];
      logic [3:0] cls;
      bit   rd, rej;
      int   total, got, guard;
      int   e_st, e_rep, e_cnt;
      bit   prev_hold;
      logic [7:0] prev_d;
      logic [7:0] prev_l;

      cls = c & 4'hB;
      rd  = c[0];
      rej = (n > MAX_PAY) || !(cls == 4'h0 || cls == 4'h1 || cls == 4'h8 || cls == 4'h9);
      total = rd ? 4 : 4 + n;
      expb[0] = a[7:0];
      expb[1] = a[15:8];
      expb[2] = {c, a[19:16]};
      expb[3][3:0] = (n == 0) ? 4'h0 : 4'(n - 1);
      expb[3][7:4] = (n == 0) ? 4'h3 : (rd ? 4'h4 : 4'((4 + n) % 16));
      for (int i = 0; i < 16; i++) expb[4+i] = 8'(8'hA0 + i*7 + n);

      @(negedge clk);
      req_addr  = a;
      req_cmd   = c;
      req_len   = LEN_W'(n);
      for (int i = 0; i < MAX_PAY; i++) req_data[i*8 +: 8] = 8'(8'hA0 + i*7 + n);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;

      if (rej) begin
         e_st = (n > MAX_PAY) ? 3 : 4;
         check_eq(rq, "reject done", done, 1);
         check_eq(rq, "reject status", res_status, e_st);
         check_eq(rq, "reject count", res_count, 0);
         check_eq(rq, "reject silent", tx_valid, 0);
         @(negedge clk);
         check_eq("R11", "single pulse", done, 0);
         check_eq(rq, "still silent", tx_valid, 0);
         return;
      end

      check_eq("R11", "busy ready low", req_ready, 0);
      got = 0; guard = 0; prev_hold = 1'b0; prev_d = '0; prev_l = '0;
      while (1) begin
         if (tx_valid !== 1'b1) begin
            check_eq(rq, "stream valid", tx_valid, 1);
            break;
         end
         if (prev_hold) begin
            check_eq("R10", "held data", tx_data, prev_d);
            check_eq("R10", "held last", tx_last, prev_l);
         end
         tx_ready = stall ? ((guard % 3) == 2) : 1'b1;
         if (tx_ready) begin
            if (got < 3)       check_eq("R3", $sformatf("byte %0d", got), tx_data, expb[got]);
            else if (got == 3) begin
               check_eq("R4", "byte3 low", tx_data[3:0], expb[3][3:0]);
               check_eq(rd ? "R6" : "R5", "byte3 high", tx_data[7:4], expb[3][7:4]);
            end else           check_eq("R5", $sformatf("payload %0d", got-4), tx_data, expb[got]);
            check_eq("R10", "last flag", tx_last, (got == total-1));
            got++;
         end
         prev_hold = !tx_ready;
         prev_d = tx_data;
         prev_l = {7'd0, tx_last};
         guard++;
         if (guard > 200) begin
            check_eq(rq, "stream hung", 1, 0);
            break;
         end
         if (tx_ready && tx_last) break;
         @(negedge clk);
      end
      check_eq(rd ? "R6" : "R5", "byte total", got, total);

      @(negedge clk);
      tx_ready = 1'b0;
      check_eq("R10", "valid drops", tx_valid, 0);
      check_eq("R11", "no early done", done, 0);

      rsp_status = st;
      rsp_len    = LEN_W'(rl);
      rsp_valid  = 1'b1;
      @(negedge clk);
      rsp_valid  = 1'b0;
      if (st == 8'd1)                     begin e_st = 1; e_rep = 0; e_cnt = 0; end
      else if (st == 8'd2 || st == 8'd3)  begin e_st = 2; e_rep = 0; e_cnt = 0; end
      else begin
         e_st = 0; e_rep = st[7:4];
         e_cnt = rd ? ((rl > n) ? n : rl) : n;
      end
      check_eq(rq, "done", done, 1);
      check_eq((e_st == 0) ? "R8" : "R7", "status", res_status, e_st);
      check_eq((e_st == 0) ? "R8" : "R7", "reply", res_reply, e_rep);
      check_eq("R9", "count", res_count, e_cnt);
      @(negedge clk);
      check_eq("R11", "pulse ends", done, 0);
      check_eq("R11", "idle again", req_ready, 1);
   endtask

   task automatic t_reset;
      check_eq("R11", "reset ready", req_ready, 1);
      check_eq("R10", "reset valid", tx_valid, 0);
      check_eq("R11", "reset done", done, 0);
   endtask

   task automatic t_native_write;   do_xfer(20'h5A3C1, 4'h8, 3, 0, 8'h00, 0, "R5"); endtask
   task automatic t_bare_write;     do_xfer(20'h00123, 4'h4, 0, 0, 8'h00, 0, "R5"); endtask
   task automatic t_full_write;     do_xfer(20'hF0F0F, 4'h8, 16, 1, 8'h10, 0, "R5"); endtask
   task automatic t_wrap_write;     do_xfer(20'h10203, 4'h0, 12, 1, 8'h00, 0, "R5"); endtask
   task automatic t_read_short;     do_xfer(20'h00200, 4'h9, 8, 0, 8'h20, 5, "R6"); endtask
   task automatic t_read_clamp;     do_xfer(20'h8ABCD, 4'h1, 2, 1, 8'h00, 9, "R9"); endtask
   task automatic t_bare_read;      do_xfer(20'h00050, 4'h5, 0, 0, 8'h00, 0, "R6"); endtask
   task automatic t_timeout;        do_xfer(20'h00300, 4'h9, 4, 0, 8'h01, 4, "R7"); endtask
   task automatic t_flags;          do_xfer(20'h00301, 4'h8, 1, 0, 8'h02, 0, "R7"); endtask
   task automatic t_error;          do_xfer(20'h00302, 4'h9, 1, 0, 8'h03, 1, "R7"); endtask
   task automatic t_odd_status;     do_xfer(20'h00303, 4'h9, 6, 0, 8'h12, 6, "R8"); endtask
   task automatic t_too_big;        do_xfer(20'h00400, 4'h8, 17, 0, 8'h00, 0, "R1"); endtask
   task automatic t_bad_cmd;
      do_xfer(20'h00401, 4'h2, 1, 0, 8'h00, 0, "R2");
      do_xfer(20'h00402, 4'hA, 1, 0, 8'h00, 0, "R2");
   endtask

   task automatic t_idle_rsp;
      @(negedge clk);
      rsp_status = 8'h20;
      rsp_len    = LEN_W'(3);
      rsp_valid  = 1'b1;
      @(negedge clk);
      rsp_valid  = 1'b0;
      check_eq("R11", "idle reply ignored", done, 0);
      check_eq("R11", "idle no stream", tx_valid, 0);
      check_eq("R11", "idle ready", req_ready, 1);
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_cmd = '0; req_len = '0;
      req_data = '0; tx_ready = 1'b0; rsp_valid = 1'b0; rsp_status = '0; rsp_len = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_native_write;
      t_bare_write;
      t_full_write;
      t_wrap_write;
      t_read_short;
      t_read_clamp;
      t_bare_read;
      t_timeout;
      t_flags;
      t_error;
      t_odd_status;
      t_too_big;
      t_bad_cmd;
      t_idle_rsp;
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule